// File: doc/BRIEF.md
# Secure-Aware Interrupt Controller

This block collects 109 level-sensitive interrupt lines (sources 0 to 108) and raises one request to the processor. Each source has four pieces of state: a security attribute, an enable, an 8-bit priority and a pending bit. Arbitration finds the most urgent pending, enabled sources. It does not return one winner. It marks every source that shares the best priority in a bitmap, and software scans that bitmap for the lowest set bit.

Software reaches everything through a 32-bit register bus with word-aligned addresses. A write takes effect on the clock edge at which `bus_we` is high. Reads are combinational from `bus_addr`. Enables are never written directly. One register array sets them and a second array clears them, so a driver can change one source without a read-modify-write. The request output is the registered OR of the highest-pending bitmap.

There is no sequencing state machine. Register decode, arbitration and the request flop are all either combinational or single-stage. The only named transitions are the request flop going from idle (low) to asserted (high) one clock after an eligible source appears, and back again one clock after the last one goes away.

Top module: `icu_top`

## Requirements
- R1: After reset, every register reads zero and `irq_out` is low.
- R2: Control word at offset 0x000: global enable in bit 0, non-secure enable in bit 16, non-secure-enable mask in bit 31. All other bits read zero.
- R3: The threshold at offset 0x00C is 8 bits wide (bits 7:0). A source can be signalled only when its priority is strictly below this value.
- R4: Offset 0x010 stores a 2-bit field in bits 1:0, and offset 0x014 stores a 1-bit field in bit 0. Neither field changes any other behaviour.
- R5: Security words start at 0x080, with bit b of word w belonging to source 32w+b. A 1 marks the source non-secure. These bits are storage only.
- R6: Enable-set words start at 0x100 and enable-clear words start at 0x180, with the same bit layout as R5. Writing a 1 sets or clears that enable, and writing a 0 leaves it unchanged. Reads of either array return the current enables.
- R7: Priority words start at 0x400. Byte k of word w is the priority of source 4w+k. A lower value means higher urgency, and 0xFF is the least urgent.
- R8: Pending words at 0xD00 mirror the input lines in the R5 layout. Writes to them are ignored.
- R9: The highest-pending words at 0xD80 use the R5 layout. A bit is 1 for each pending, enabled source whose priority equals the minimum priority among pending, enabled sources, provided that minimum is below the threshold. Every bit is 0 while the global enable is 0.
- R10: `irq_out` is the OR of the highest-pending bitmap, delayed by one clock.
- R11: Undefined or unaligned offsets read zero and ignore writes. Bits for sources above 108 in the last word of each array read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_irq | input | 109 | Level-sensitive interrupt lines, one per source |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 12 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_out | output | 1 | Request to the processor |

## Verification
Arbitration is tried with several input patterns:
- A single pending source, which shows that a lone winner is found.
- Two sources that tie on the best priority, which tells a tie bitmap apart from a single-winner encoder.
- A more urgent source added on top of that tie, which checks that the minimum is recomputed.
- The same pattern under thresholds equal to and one above the minimum, which separates a strict comparison from an inclusive one.

All lines are then driven at once, which checks that the scan over the whole array picks the right source. Clearing the global enable, and clearing the enable of the winning source, show whether the gating and the set/clear arrays reach the bitmap. The request output is sampled both at the write edge and one edge later to confirm its single-cycle delay.

// File: rtl/icu_pkg.sv
package icu_pkg;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;

    localparam int OFS_CTRL  = 'h000;
    localparam int OFS_MASK  = 'h00C;
    localparam int OFS_SYNC  = 'h010;
    localparam int OFS_DSM   = 'h014;
    localparam int OFS_SEC   = 'h080;
    localparam int OFS_ENSET = 'h100;
    localparam int OFS_ENCLR = 'h180;
    localparam int OFS_PRIO  = 'h400;
    localparam int OFS_PEND  = 'hD00;
    localparam int OFS_HIPND = 'hD80;

    function automatic logic in_range(input int a, input int base, input int words);
        return (a >= base) && (a < base + 4 * words);
    endfunction
endpackage

// File: rtl/icu_arbiter.sv
module icu_arbiter #(
    parameter int NUM_SRC = 109,
    parameter int PRIO_W  = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        glb_en,
    input  logic [NUM_SRC-1:0]          pend,
    input  logic [NUM_SRC-1:0]          en,
    input  logic [NUM_SRC*PRIO_W-1:0]   prio_flat,
    input  logic [PRIO_W-1:0]           mask,
    output logic [NUM_SRC-1:0]          hp
);
    logic [NUM_SRC-1:0] elig;
    logic [PRIO_W-1:0]  minv;

    assign elig = pend & en;

    always_comb begin
        minv = '1;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (elig[i] && (prio_flat[i*PRIO_W +: PRIO_W] < minv))
                minv = prio_flat[i*PRIO_W +: PRIO_W];
        end
    end

    always_comb begin
        for (int i = 0; i < NUM_SRC; i++)
            hp[i] = glb_en && elig[i] && (minv < mask) &&
                    (prio_flat[i*PRIO_W +: PRIO_W] == minv);
    end

    // R3
    hp_mask_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> (hp == '0));

    // R9
    hp_no_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_en |-> (hp == '0));
endmodule

// File: rtl/icu_regfile.sv
module icu_regfile
    import icu_pkg::*;
#(
    parameter int NUM_SRC = 109,
    parameter int PRIO_W  = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_we,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [DATA_W-1:0]           bus_wdata,
    output logic [DATA_W-1:0]           bus_rdata,
    input  logic [NUM_SRC-1:0]          pend,
    input  logic [NUM_SRC-1:0]          hp,
    output logic                        glb_en,
    output logic [NUM_SRC-1:0]          en,
    output logic [NUM_SRC*PRIO_W-1:0]   prio_flat,
    output logic [PRIO_W-1:0]           mask
);
    localparam int NW  = (NUM_SRC + DATA_W - 1) / DATA_W;
    localparam int PER = DATA_W / PRIO_W;
    localparam int PW  = (NUM_SRC + PER - 1) / PER;
    localparam int PAD = NW * DATA_W;
    localparam logic [PAD-1:0] VALID = {{(PAD-NUM_SRC){1'b0}}, {NUM_SRC{1'b1}}};

    logic                ns_en_q, ns_mask_q, dsm_q;
    logic [1:0]          sync_q;
    logic [NUM_SRC-1:0]  sec_q, en_q;
    logic [PRIO_W-1:0]   prio_q [NUM_SRC];
    logic [PAD-1:0]      sec_pad, en_pad, pend_pad, hp_pad;

    int  a;
    logic aligned;
    logic h_sec, h_set, h_clr, h_prio, h_pend, h_hip;
    int  idx_sec, idx_set, idx_clr, idx_prio, idx_pend, idx_hip;

    assign a       = int'(bus_addr);
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign h_sec   = aligned && in_range(a, OFS_SEC,   NW);
    assign h_set   = aligned && in_range(a, OFS_ENSET, NW);
    assign h_clr   = aligned && in_range(a, OFS_ENCLR, NW);
    assign h_prio  = aligned && in_range(a, OFS_PRIO,  PW);
    assign h_pend  = aligned && in_range(a, OFS_PEND,  NW);
    assign h_hip   = aligned && in_range(a, OFS_HIPND, NW);
    assign idx_sec  = (a - OFS_SEC)   >> 2;
    assign idx_set  = (a - OFS_ENSET) >> 2;
    assign idx_clr  = (a - OFS_ENCLR) >> 2;
    assign idx_prio = (a - OFS_PRIO)  >> 2;
    assign idx_pend = (a - OFS_PEND)  >> 2;
    assign idx_hip  = (a - OFS_HIPND) >> 2;

    assign sec_pad  = PAD'(sec_q);
    assign en_pad   = PAD'(en_q);
    assign pend_pad = PAD'(pend);
    assign hp_pad   = PAD'(hp);

    // scalar control registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            glb_en    <= 1'b0;
            ns_en_q   <= 1'b0;
            ns_mask_q <= 1'b0;
            mask      <= '0;
            sync_q    <= '0;
            dsm_q     <= 1'b0;
        end else if (bus_we && aligned) begin
            if (a == OFS_CTRL) begin
                glb_en    <= bus_wdata[0];
                ns_en_q   <= bus_wdata[16];
                ns_mask_q <= bus_wdata[31];
            end
            if (a == OFS_MASK) mask   <= bus_wdata[PRIO_W-1:0];
            if (a == OFS_SYNC) sync_q <= bus_wdata[1:0];
            if (a == OFS_DSM)  dsm_q  <= bus_wdata[0];
        end
    end

    // per-source arrays
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q <= '0;
            en_q  <= '0;
            for (int i = 0; i < NUM_SRC; i++) prio_q[i] <= '0;
        end else if (bus_we) begin
            for (int i = 0; i < NUM_SRC; i++) begin
                if (h_sec && idx_sec == i / DATA_W)
                    sec_q[i] <= bus_wdata[i % DATA_W];
                if (h_set && idx_set == i / DATA_W && bus_wdata[i % DATA_W])
                    en_q[i] <= 1'b1;
                if (h_clr && idx_clr == i / DATA_W && bus_wdata[i % DATA_W])
                    en_q[i] <= 1'b0;
                if (h_prio && idx_prio == i / PER)
                    prio_q[i] <= bus_wdata[(i % PER)*PRIO_W +: PRIO_W];
            end
        end
    end

    generate
        for (genvar g = 0; g < NUM_SRC; g++) begin : g_prio_out
            assign prio_flat[g*PRIO_W +: PRIO_W] = prio_q[g];
        end
    endgenerate

    assign en = en_q;

    // read multiplexer
    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            if (a == OFS_CTRL) begin
                bus_rdata[0]  = glb_en;
                bus_rdata[16] = ns_en_q;
                bus_rdata[31] = ns_mask_q;
            end
            if (a == OFS_MASK) bus_rdata[PRIO_W-1:0] = mask;
            if (a == OFS_SYNC) bus_rdata[1:0] = sync_q;
            if (a == OFS_DSM)  bus_rdata[0]   = dsm_q;
            if (h_sec)  bus_rdata = sec_pad[idx_sec*DATA_W +: DATA_W];
            if (h_set)  bus_rdata = en_pad[idx_set*DATA_W +: DATA_W];
            if (h_clr)  bus_rdata = en_pad[idx_clr*DATA_W +: DATA_W];
            if (h_pend) bus_rdata = pend_pad[idx_pend*DATA_W +: DATA_W];
            if (h_hip)  bus_rdata = hp_pad[idx_hip*DATA_W +: DATA_W];
            if (h_prio) begin
                for (int k = 0; k < PER; k++) begin
                    if (idx_prio * PER + k < NUM_SRC)
                        bus_rdata[k*PRIO_W +: PRIO_W] = prio_q[idx_prio * PER + k];
                end
            end
        end
    end

    // checker state for the set/clear arrays
    logic              set_seen, clr_seen;
    logic [DATA_W-1:0] set_bits, clr_bits;
    int                set_word, clr_word;
    logic [PAD-1:0]    valid_v;
    assign valid_v = VALID;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            set_seen <= 1'b0;
            clr_seen <= 1'b0;
            set_bits <= '0;
            clr_bits <= '0;
            set_word <= 0;
            clr_word <= 0;
        end else begin
            set_seen <= bus_we && h_set && !(h_clr);
            clr_seen <= bus_we && h_clr;
            set_word <= idx_set;
            clr_word <= idx_clr;
            set_bits <= bus_wdata & valid_v[idx_set*DATA_W +: DATA_W];
            clr_bits <= bus_wdata & valid_v[idx_clr*DATA_W +: DATA_W];
        end
    end

    // R6
    enset_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_seen |-> ((en_pad[set_word*DATA_W +: DATA_W] & set_bits) == set_bits));

    // R6
    enclr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_seen |-> ((en_pad[clr_word*DATA_W +: DATA_W] & clr_bits) == '0));
endmodule

// File: rtl/icu_top.sv
module icu_top
    import icu_pkg::*;
#(
    parameter int NUM_SRC = 109,
    parameter int PRIO_W  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SRC-1:0]  src_irq,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                irq_out
);
    logic                       glb_en;
    logic [NUM_SRC-1:0]         en, hp;
    logic [NUM_SRC*PRIO_W-1:0]  prio_flat;
    logic [PRIO_W-1:0]          mask;

    icu_regfile #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pend      (src_irq),
        .hp        (hp),
        .glb_en    (glb_en),
        .en        (en),
        .prio_flat (prio_flat),
        .mask      (mask)
    );

    icu_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .glb_en    (glb_en),
        .pend      (src_irq),
        .en        (en),
        .prio_flat (prio_flat),
        .mask      (mask),
        .hp        (hp)
    );

    // request flop: idle <-> asserted, one clock behind the bitmap
    always_ff @(posedge clk) begin
        if (!rst_n) irq_out <= 1'b0;
        else        irq_out <= |hp;
    end

    // R10
    irq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_en |=> !irq_out);

    // R9
    hp_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((hp & ~(src_irq & en)) == '0));

    // R10
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hp == '0) |=> !irq_out);
endmodule

// File: tb/sim_icu_top.sv
module sim_icu_top;
    localparam int N = 109;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  src_irq = '0;
    logic          bus_we = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          irq_out;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    icu_top u0 (
        .clk(clk), .rst_n(rst_n), .src_irq(src_irq), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_out(irq_out)
    );

    typedef struct packed {
        logic [N-1:0] src;
        logic [7:0]   mask;
        logic [7:0]   cnt;
        logic [7:0]   low;
    } vec_t;

    localparam logic [N-1:0] S3   = N'(1) << 3;
    localparam logic [N-1:0] S355 = (N'(1) << 3) | (N'(1) << 5) | (N'(1) << 60);
    localparam logic [N-1:0] S4   = S355 | (N'(1) << 108);
    localparam logic [N-1:0] S0   = N'(1);
    localparam logic [N-1:0] SALL = '1;

    localparam vec_t TAB [8] = '{
        '{S3,   8'hFF, 8'd1, 8'd3},
        '{S355, 8'hFF, 8'd2, 8'd5},
        '{S4,   8'hFF, 8'd1, 8'd108},
        '{S4,   8'h05, 8'd0, 8'd127},
        '{S0,   8'h80, 8'd0, 8'd127},
        '{S0,   8'h81, 8'd1, 8'd0},
        '{SALL, 8'hFF, 8'd1, 8'd108},
        '{SALL, 8'h05, 8'd0, 8'd127}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] ad, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = ad; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] ad, output logic [31:0] d);
        bus_addr = ad; #1;
        d = bus_rdata;
    endtask

    task automatic get_hp(output int cnt, output int low);
        logic [31:0] w;
        cnt = 0; low = 127;
        for (int k = 0; k < 4; k++) begin
            rd(12'hD80 + 12'(4*k), w);
            for (int b = 31; b >= 0; b--) begin
                if (w[b]) begin
                    cnt++;
                    if (32*k + b < low) low = 32*k + b;
                end
            end
        end
    endtask

    initial begin
        #(20 * 50000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int c, l;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        chk("R1 irq", {31'b0, irq_out}, 0);
        rd(12'h000, d); chk("R1 ctrl", d, 0);
        rd(12'h100, d); chk("R1 enable", d, 0);
        rd(12'h400, d); chk("R1 prio", d, 0);
        rd(12'h00C, d); chk("R1 mask", d, 0);

        // setup: enable, all sources on, priorities
        wr(12'h000, 32'h1);
        for (int k = 0; k < 4; k++) wr(12'h100 + 12'(4*k), 32'hFFFF_FFFF);
        for (int k = 0; k < 28; k++) wr(12'h400 + 12'(4*k), 32'h8080_8080);
        wr(12'h400, 32'h4080_8080);
        wr(12'h404, 32'h8080_1080);
        wr(12'h43C, 32'h8080_8010);
        wr(12'h46C, 32'h8080_8005);
        rd(12'h404, d); chk("R7 prio lanes", d, 32'h8080_1080);
        rd(12'h46C, d); chk("R11 prio last word", d, 32'h0000_0005);

        // table walk (R3, R9, R10)
        foreach (TAB[i]) begin
            @(negedge clk); src_irq = TAB[i].src;
            wr(12'h00C, {24'b0, TAB[i].mask});
            @(posedge clk); #1;
            get_hp(c, l);
            chk($sformatf("R9 row%0d count", i), c, TAB[i].cnt);
            chk($sformatf("R9 row%0d lowest", i), l, TAB[i].low);
            chk($sformatf("R10 R3 row%0d irq", i), {31'b0, irq_out}, (TAB[i].cnt != 0));
        end

        // R8 pending mirrors lines, writes ignored
        @(negedge clk); src_irq = S355;
        wr(12'hD00, 32'h0);
        rd(12'hD00, d); chk("R8 pend w0", d, 32'h0000_0028);
        rd(12'hD04, d); chk("R8 pend w1", d, 32'h1000_0000);

        // R10 timing with global enable toggle, R9 gating
        @(negedge clk); src_irq = SALL;
        wr(12'h00C, 32'hFF);
        wr(12'h000, 32'h0);
        @(posedge clk); #1;
        get_hp(c, l);
        chk("R9 disabled bitmap", c, 0);
        chk("R10 disabled irq", {31'b0, irq_out}, 0);
        wr(12'h000, 32'h1);
        chk("R10 irq not yet", {31'b0, irq_out}, 0);
        @(posedge clk); #1;
        chk("R10 irq one clock later", {31'b0, irq_out}, 1);

        // R6 clear winner, zero writes no effect
        wr(12'h18C, 32'h0000_1000);
        rd(12'h10C, d); chk("R6 clear read via set", d, 32'h0000_0FFF);
        rd(12'h18C, d); chk("R6 clear read via clr", d, 32'h0000_0FFF);
        get_hp(c, l);
        chk("R6 R9 new tie count", c, 2);
        chk("R6 R9 new tie lowest", l, 5);
        wr(12'h100, 32'h0);
        rd(12'h100, d); chk("R6 zero set", d, 32'hFFFF_FFFF);
        wr(12'h180, 32'h0);
        rd(12'h100, d); chk("R6 zero clear", d, 32'hFFFF_FFFF);

        // R5, R11 security bits
        wr(12'h08C, 32'hFFFF_FFFF);
        rd(12'h08C, d); chk("R5 R11 sec last word", d, 32'h0000_1FFF);
        get_hp(c, l);
        chk("R5 no arbitration effect", c, 2);

        // R2 control layout
        wr(12'h000, 32'hFFFF_FFFF);
        rd(12'h000, d); chk("R2 ctrl", d, 32'h8001_0001);
        // R3 mask width
        wr(12'h00C, 32'hFFFF_FFFF);
        rd(12'h00C, d); chk("R3 mask", d, 32'h0000_00FF);
        // R4 storage
        wr(12'h010, 32'hFFFF_FFFF);
        rd(12'h010, d); chk("R4 sync", d, 32'h3);
        wr(12'h014, 32'hFFFF_FFFF);
        rd(12'h014, d); chk("R4 dsm", d, 32'h1);
        get_hp(c, l);
        chk("R4 no effect", c, 2);

        // R11 undefined offsets
        wr(12'h020, 32'hFFFF_FFFF);
        rd(12'h020, d); chk("R11 undefined", d, 0);
        rd(12'h470, d); chk("R11 past prio", d, 0);
        wr(12'h102, 32'hFFFF_FFFF);
        rd(12'h10C, d); chk("R11 unaligned ignored", d, 32'h0000_0FFF);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule